// File: doc/BRIEF.md
# Audio sample-flow status unit

This unit monitors the health of a stereo 16-bit audio path that runs between a host and a pair of converters. A one-cycle sample tick marks each sample period. On each tick the unit does three things. It checks whether the host supplied a new playback pair since the previous tick. It checks whether the host collected the previous capture pair. It grades how loud each newly captured channel is.

The unit holds a single playback pair and a single capture pair. A missing playback pair sends silence (zero) to the converters and raises an underrun flag. A capture pair that arrives while the held one is still unread is discarded, and an overrun flag is raised. The unit also reports two other conditions: that calibration is running or a mode change ended recently, and that a data request line is active. All of this appears in a read-only 8-bit status byte and a one-bit summary flag.

The level grading compares the magnitude of each two's-complement sample against three parameter thresholds: the -1 dB point, the 0 dB point and the +1 dB point.

Top module: `audio_flow_status`

## Requirements
- R1: After reset, `status`, `ovr_undr`, both converter outputs and both held capture outputs are zero.
- R2: At a tick with no fresh playback pair, status bit 6 (underrun) becomes 1 and both converter outputs become 16'h0000 after that clock edge. A pair is fresh if `pb_wr` was high in any cycle after the previous tick, including the tick cycle itself.
- R3: At a tick with a fresh pair, the converters receive the most recently written pair and bit 6 becomes 0. A pair is used at one tick only.
- R4: At a tick where the held capture pair is unread and `cap_rd` is low, status bit 7 (overrun) becomes 1. The held pair is kept and the incoming pair is discarded.
- R5: At a tick where the held pair was read, or is being read in the same cycle, the incoming pair is taken and bit 7 becomes 0. `cap_rd` outside a tick marks the held pair as read.
- R6: At every tick, including one whose pair is discarded, the level code of the incoming left channel goes to bits 1:0 and that of the right channel to bits 3:2. With m the magnitude of the sample, the code is 3 if m > LVL_P1, else 2 if m >= LVL_0, else 1 if m >= LVL_M1, else 0.
- R7: Status bit 4 equals `pb_req | cap_req` in the same cycle.
- R8: Status bit 5 is 1 whenever `cal_busy` is high. A falling edge of `mce` makes bit 5 read 1 for exactly WIN (128) following ticks, starting at the edge where the falling level is seen.
- R9: `ovr_undr` equals status bit 7 OR status bit 6.
- R10: Bits 7, 6 and 3:0 change only at the clock edge of a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle sample-period strobe |
| pb_wr | input | 1 | Host playback write strobe |
| pb_l | input | 16 | Playback left word |
| pb_r | input | 16 | Playback right word |
| dac_l | output | 16 | Left converter word |
| dac_r | output | 16 | Right converter word |
| cin_l | input | 16 | Incoming capture left sample |
| cin_r | input | 16 | Incoming capture right sample |
| cap_rd | input | 1 | Host capture read strobe |
| cap_l | output | 16 | Held capture left sample |
| cap_r | output | 16 | Held capture right sample |
| pb_req | input | 1 | Playback request line level |
| cap_req | input | 1 | Capture request line level |
| mce | input | 1 | Mode-change enable bit |
| cal_busy | input | 1 | Calibration running |
| status | output | 8 | {overrun, underrun, cal, request, right code[1:0], left code[1:0]} |
| ovr_undr | output | 1 | Summary of overrun and underrun |

## Verification
The random stimulus mixes several conditions: ticks with and without prior playback writes, writes that land in the tick cycle itself, and reads that come before, during or after a tick. Together these separate correct fresh-word consumption from stale reuse, and dropping a capture pair from overwriting it. Samples are drawn around each threshold and at both extremes, so an off-by-one in a comparison or in the negative-magnitude path changes the code. Directed runs count the calibration window tick by tick after a mode-change exit, which exposes a window that is one tick too long or too short.

// File: rtl/audio_flow_status.sv
module audio_flow_status #(
  parameter int W      = 16,
  parameter int WIN    = 128,
  parameter int CW     = 8,
  parameter int LVL_M1 = 26029,
  parameter int LVL_0  = 29204,
  parameter int LVL_P1 = 32767
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         pb_wr,
  input  logic [W-1:0] pb_l,
  input  logic [W-1:0] pb_r,
  output logic [W-1:0] dac_l,
  output logic [W-1:0] dac_r,
  input  logic [W-1:0] cin_l,
  input  logic [W-1:0] cin_r,
  input  logic         cap_rd,
  output logic [W-1:0] cap_l,
  output logic [W-1:0] cap_r,
  input  logic         pb_req,
  input  logic         cap_req,
  input  logic         mce,
  input  logic         cal_busy,
  output logic [7:0]   status,
  output logic         ovr_undr
);

  function automatic logic [1:0] grade(input logic [W-1:0] s);
    logic [W:0] m;
    m = s[W-1] ? ({1'b0, ~s} + 1'b1) : {1'b0, s};
    if (m > (W+1)'(LVL_P1))       grade = 2'd3;
    else if (m >= (W+1)'(LVL_0))  grade = 2'd2;
    else if (m >= (W+1)'(LVL_M1)) grade = 2'd1;
    else                          grade = 2'd0;
  endfunction

  logic         pb_fresh, cap_full, cor, pur, mce_q;
  logic [W-1:0] pb_bl, pb_br;
  logic [1:0]   orl, orr;
  logic [CW-1:0] win_cnt;

  wire fresh  = pb_fresh | pb_wr;
  wire take   = ~cap_full | cap_rd;
  wire aci    = cal_busy | (win_cnt != '0);

  assign status   = {cor, pur, aci, pb_req | cap_req, orr, orl};
  assign ovr_undr = cor | pur;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pb_fresh <= 1'b0;
      pb_bl    <= '0;
      pb_br    <= '0;
      dac_l    <= '0;
      dac_r    <= '0;
      pur      <= 1'b0;
    end else begin
      if (pb_wr) begin
        pb_bl <= pb_l;
        pb_br <= pb_r;
      end
      if (tick) begin
        pb_fresh <= 1'b0;
        pur      <= ~fresh;
        dac_l    <= !fresh ? '0 : (pb_wr ? pb_l : pb_bl);
        dac_r    <= !fresh ? '0 : (pb_wr ? pb_r : pb_br);
      end else begin
        pb_fresh <= fresh;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_full <= 1'b0;
      cap_l    <= '0;
      cap_r    <= '0;
      cor      <= 1'b0;
      orl      <= 2'd0;
      orr      <= 2'd0;
    end else if (tick) begin
      orl <= grade(cin_l);
      orr <= grade(cin_r);
      cor <= ~take;
      if (take) begin
        cap_l    <= cin_l;
        cap_r    <= cin_r;
        cap_full <= 1'b1;
      end
    end else if (cap_rd) begin
      cap_full <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mce_q   <= 1'b0;
      win_cnt <= '0;
    end else begin
      mce_q <= mce;
      if (mce_q && !mce)
        win_cnt <= CW'(WIN);
      else if (tick && win_cnt != '0)
        win_cnt <= win_cnt - 1'b1;
    end
  end

  // R2
  midscale_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !pb_fresh && !pb_wr) |=> (dac_l == '0 && dac_r == '0 && status[6]));

  // R4
  held_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cap_full && !cap_rd) |=> ($stable(cap_l) && $stable(cap_r) && status[7]));

  // R10
  flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(status[7:6]) && $stable(status[3:0])));

  // R8
  window_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mce_q && !mce) |=> status[5]);

  // R8
  window_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_cnt <= CW'(WIN));

endmodule

// File: tb/test_audio_flow_status.sv
module test_audio_flow_status;
  localparam int W = 16, WIN = 128;
  localparam int T_M1 = 26029, T_0 = 29204, T_P1 = 32767;

  logic clk = 0, rst_n = 0;
  logic tick = 0, pb_wr = 0, cap_rd = 0, pb_req = 0, cap_req = 0, mce = 0, cal_busy = 0;
  logic [W-1:0] pb_l = 0, pb_r = 0, cin_l = 0, cin_r = 0;
  logic [W-1:0] dac_l, dac_r, cap_l, cap_r;
  logic [7:0] status;
  logic ovr_undr;

  audio_flow_status i_audio_flow_status (
    .clk(clk), .rst_n(rst_n), .tick(tick), .pb_wr(pb_wr), .pb_l(pb_l), .pb_r(pb_r),
    .dac_l(dac_l), .dac_r(dac_r), .cin_l(cin_l), .cin_r(cin_r), .cap_rd(cap_rd),
    .cap_l(cap_l), .cap_r(cap_r), .pb_req(pb_req), .cap_req(cap_req), .mce(mce),
    .cal_busy(cal_busy), .status(status), .ovr_undr(ovr_undr));

  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic m_fresh, m_full, m_cor, m_pur, m_mceq;
  logic [W-1:0] m_bl, m_br, m_dl, m_dr, m_cl, m_cr;
  logic [1:0] m_orl, m_orr;
  int m_cnt;

  function automatic logic [1:0] lvl(input logic [W-1:0] s);
    int v, m;
    v = int'($signed(s));
    m = (v < 0) ? -v : v;
    if (m > T_P1) return 2'd3;
    if (m >= T_0) return 2'd2;
    if (m >= T_M1) return 2'd1;
    return 2'd0;
  endfunction

  function automatic logic [7:0] exp_status();
    return {m_cor, m_pur, cal_busy | (m_cnt != 0), pb_req | cap_req, m_orr, m_orl};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_fresh = 0; m_full = 0; m_cor = 0; m_pur = 0; m_mceq = 0;
    m_bl = 0; m_br = 0; m_dl = 0; m_dr = 0; m_cl = 0; m_cr = 0;
    m_orl = 0; m_orr = 0; m_cnt = 0;
  endtask

  task automatic model_edge();
    logic f;
    f = m_fresh | pb_wr;
    if (tick) begin
      m_dl = f ? (pb_wr ? pb_l : m_bl) : '0;
      m_dr = f ? (pb_wr ? pb_r : m_br) : '0;
      m_pur = !f;
      m_fresh = 0;
    end else m_fresh = f;
    if (pb_wr) begin m_bl = pb_l; m_br = pb_r; end
    if (tick) begin
      m_orl = lvl(cin_l); m_orr = lvl(cin_r);
      if (m_full && !cap_rd) m_cor = 1;
      else begin m_cor = 0; m_cl = cin_l; m_cr = cin_r; m_full = 1; end
    end else if (cap_rd) m_full = 0;
    if (m_mceq && !mce) m_cnt = WIN;
    else if (tick && m_cnt != 0) m_cnt--;
    m_mceq = mce;
  endtask

  task automatic compare_all();
    logic [7:0] e;
    e = exp_status();
    chk("R9 summary", ovr_undr, e[7] | e[6]);
    chk("R4 R5 overrun bit", status[7], e[7]);
    chk("R2 R3 underrun bit", status[6], e[6]);
    chk("R8 cal bit", status[5], e[5]);
    chk("R7 request bit", status[4], e[4]);
    chk("R6 right code", status[3:2], e[3:2]);
    chk("R6 left code", status[1:0], e[1:0]);
    chk("R2 R3 dac left", dac_l, m_dl);
    chk("R2 R3 dac right", dac_r, m_dr);
    chk("R4 R5 capture left", cap_l, m_cl);
    chk("R4 R5 capture right", cap_r, m_cr);
  endtask

  task automatic cyc();
    @(posedge clk);
    if (rst_n) model_edge(); else model_reset();
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle();
    tick = 0; pb_wr = 0; cap_rd = 0;
  endtask

  function automatic logic [W-1:0] pick_sample();
    int k;
    k = $urandom_range(0, 9);
    case (k)
      0: return W'(T_M1 - 1);
      1: return W'(T_M1);
      2: return W'(T_0 - 1);
      3: return W'(T_0);
      4: return W'(-T_M1);
      5: return W'(-T_0 + 1);
      6: return 16'h8000;
      7: return 16'h7FFF;
      default: return W'($urandom);
    endcase
  endfunction

  initial begin
    void'($urandom(32'h5eed_1234));
    model_reset();
    repeat (3) cyc();
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset status", status, 8'h00);
    chk("R1 reset summary", ovr_undr, 1'b0);
    chk("R1 reset dac", {dac_l, dac_r}, 32'h0);
    chk("R1 reset capture", {cap_l, cap_r}, 32'h0);

    // R2: tick with nothing written
    idle(); tick = 1; cin_l = 16'h1000; cin_r = 16'h2000; cyc();
    chk("R2 underrun set", status[6], 1'b1);
    chk("R2 midscale", dac_l, 16'h0000);
    idle(); cyc();
    // R3: write in tick cycle itself
    tick = 1; pb_wr = 1; pb_l = 16'h1234; pb_r = 16'hABCD; cap_rd = 1; cyc();
    chk("R3 same-cycle write", {dac_l, dac_r}, 32'h1234ABCD);
    chk("R3 underrun clear", status[6], 1'b0);
    // R4: unread capture at next tick
    idle(); cyc();
    tick = 1; cin_l = 16'h5555; cin_r = 16'h6666; cyc();
    chk("R4 overrun set", status[7], 1'b1);
    chk("R4 held kept", cap_l, 16'h1000);
    chk("R3 word used once", status[6], 1'b1);
    // R6 extremes
    idle(); cap_rd = 1; cyc();
    idle(); tick = 1; cin_l = 16'h8000; cin_r = W'(T_0); cyc();
    chk("R6 negative full scale", status[1:0], 2'd3);
    chk("R6 0 dB point", status[3:2], 2'd2);
    chk("R5 accepted after read", status[7], 1'b0);

    // R8 window length
    idle(); mce = 1; cyc(); cyc();
    mce = 0; cyc();
    chk("R8 window starts", status[5], 1'b1);
    for (int i = 0; i < WIN; i++) begin
      tick = 1; cyc(); tick = 0;
      if (i == WIN - 2) chk("R8 window still on", status[5], 1'b1);
    end
    chk("R8 window ends", status[5], 1'b0);
    cal_busy = 1; @(posedge clk); @(negedge clk);
    chk("R8 calibration busy", status[5], 1'b1);
    cal_busy = 0; m_fresh = m_fresh;

    // random mix
    for (int i = 0; i < 6000; i++) begin
      tick    = ($urandom_range(0, 3) == 0);
      pb_wr   = ($urandom_range(0, 2) == 0);
      cap_rd  = ($urandom_range(0, 2) == 0);
      pb_l    = W'($urandom); pb_r = W'($urandom);
      cin_l   = pick_sample(); cin_r = pick_sample();
      pb_req  = $urandom_range(0, 1); cap_req = $urandom_range(0, 1);
      if ($urandom_range(0, 199) == 0) mce = ~mce;
      cal_busy = ($urandom_range(0, 49) == 0);
      cyc();
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule